// File: doc/BRIEF.md
# Converter Serial Frame Interface

This block is the device side of the serial port of a 14-bit converter. A fast internal system clock oversamples the chip-select, serial clock and serial data inputs. A falling chip-select opens a frame and starts a conversion, which a small timer models. During the frame the host shifts in a 16-bit configuration word on serial clock falling edges. After that, the block shifts the conversion result out on the same edges. The serial output is driven only while the frame is open. Outside a frame the output-enable is low, so the pad can float.

The channel register uses the low bits of the configuration word. It is loaded when chip-select rises, but only if the full word arrived. The channel converted in a frame is therefore the one requested in the frame before. The result value comes from a test input, `result_in`, which is captured when the modelled conversion finishes. A late-data flag reports a frame whose sixteenth falling edge came before the conversion had finished.

Top module: `adc_frame_if`

## Requirements
- R1: The first clock after the block detects chip-select low raises `sdo_oe`. `sdo` then stays 0 until the block has counted 16 serial clock falling edges.
- R2: Once chip-select is seen high again, `sdo_oe` is 0 and `sdo` is 0.
- R3: The configuration word is taken MSB first, one bit on each of falling edges 1 to 16 of the frame. Bits on `sdi` after edge 16 do not change the word.
- R4: Falling edge 16 puts result bit 13 on `sdo`. Each later falling edge moves down one bit, so result bit 0 appears after edge 29.
- R5: From falling edge 30 until the frame closes, `sdo` is 0.
- R6: The channel register takes word bits [CHAN_W-1:0] when chip-select rises. `conv_chan` shows the channel register as it stood when the current frame opened.
- R7: A frame that closes after fewer than 16 falling edges leaves the channel register unchanged.
- R8: `late_err` is set at falling edge 16 if the conversion is still busy. It is cleared when the next frame opens, and otherwise it holds.
- R9: The result shifted out is the value of `result_in` exactly CONV_CYCLES clocks after chip-select low is detected. Changes to `result_in` before or after that moment do not matter.
- R10: Serial clock edges while chip-select is high have no effect.
- R11: Reset clears `sdo`, `sdo_oe`, `late_err` and `conv_chan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal system clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock from the host; data moves on its falling edge |
| sdi | input | 1 | Serial configuration data from the host |
| result_in | input | DATA_W | Test value that stands in for the conversion result |
| sdo | output | 1 | Serial result data |
| sdo_oe | output | 1 | Drive enable for the serial output pad |
| conv_chan | output | CHAN_W | Channel being converted in the current frame |
| late_err | output | 1 | The result was requested before the conversion finished |

## Verification
A wrong edge count shows up as data shifted by whole bit positions. It can also make the zero tail begin early or late, and this appears on `sdo` within one serial clock period of the fault. A bad configuration path stays hidden for a whole frame: only the next frame's `conv_chan` reveals it. That includes short frames being accepted, or trailing `sdi` bits leaking into the word. A fault in the conversion timer shows up either as the wrong capture of a `result_in` that changes during the frame, or as a `late_err` that disagrees with how fast the host clocked. The reference model follows the synchronised pins every clock, so any such divergence is seen in the first clock where the outputs differ.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

   // one clock's worth of decoded pin activity
   typedef struct packed {
      logic cs_fall;
      logic cs_rise;
      logic cs_act;
      logic sclk_fall;
      logic sdi;
   } frm_evt_t;

   // pin order inside the synchroniser bus
   localparam int PIN_CS   = 2;
   localparam int PIN_SCLK = 1;
   localparam int PIN_SDI  = 0;

endpackage

// File: rtl/adc_frame_sync.sv
module adc_frame_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] lvl
);

   if (STAGES < 2) begin : g_bad_stages
      $error("adc_frame_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < W; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
         else        chain <= {chain[STAGES-2:0], din[g]};
      end
      assign lvl[g] = chain[STAGES-1];
   end

endmodule

// File: rtl/adc_frame_conv.sv
module adc_frame_conv #(
   parameter int DATA_W      = 14,
   parameter int CONV_CYCLES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] result_in,
   output logic              busy,
   output logic [DATA_W-1:0] result_q
);

   localparam int TMR_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;

   if (CONV_CYCLES < 1) begin : g_bad_conv
      $error("adc_frame_conv: CONV_CYCLES must be positive");
   end

   logic [TMR_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         remain   <= '0;
         result_q <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         remain <= TMR_W'(CONV_CYCLES - 1);
      end else if (busy) begin
         if (remain == '0) begin
            busy     <= 1'b0;
            result_q <= result_in;
         end else begin
            remain <= remain - 1'b1;
         end
      end
   end

endmodule

// File: rtl/adc_frame_serdes.sv
module adc_frame_serdes
   import adc_frame_pkg::*;
#(
   parameter int CFG_W  = 16,
   parameter int DATA_W = 14,
   parameter int CHAN_W = 3,
   localparam int FRAME_LEN = CFG_W + DATA_W,
   localparam int CNT_W     = $clog2(FRAME_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  frm_evt_t          evt,
   input  logic              busy,
   input  logic [DATA_W-1:0] result_q,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              late_err,
   output logic [CHAN_W-1:0] cfg_chan,
   output logic              cfg_full,
   output logic [CNT_W-1:0]  edge_cnt
);

   localparam logic [CNT_W-1:0] CNT_CFG = CNT_W'(CFG_W);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FRAME_LEN);

   logic [CNT_W-1:0]  cnt_nx;
   logic [DATA_W-1:0] dsh;

   assign cnt_nx   = (edge_cnt == CNT_END) ? edge_cnt : edge_cnt + 1'b1;
   assign cfg_full = (edge_cnt >= CNT_CFG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdo      <= 1'b0;
         sdo_oe   <= 1'b0;
         late_err <= 1'b0;
         edge_cnt <= '0;
         cfg_chan <= '0;
         dsh      <= '0;
      end else if (evt.cs_fall) begin
         sdo_oe   <= 1'b1;
         sdo      <= 1'b0;
         late_err <= 1'b0;
         edge_cnt <= '0;
      end else if (evt.cs_rise) begin
         sdo_oe <= 1'b0;
         sdo    <= 1'b0;
      end else if (evt.cs_act && evt.sclk_fall) begin
         edge_cnt <= cnt_nx;
         if (cnt_nx <= CNT_CFG)
            cfg_chan <= CHAN_W'({cfg_chan, evt.sdi});
         if (cnt_nx == CNT_CFG) begin
            late_err <= busy;
            sdo      <= result_q[DATA_W-1];
            dsh      <= DATA_W'({result_q, 1'b0});
         end else if (cnt_nx > CNT_CFG && cnt_nx < CNT_END) begin
            sdo <= dsh[DATA_W-1];
            dsh <= DATA_W'({dsh, 1'b0});
         end else if (cnt_nx > CNT_CFG) begin
            sdo <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/adc_frame_if.sv
module adc_frame_if
   import adc_frame_pkg::*;
#(
   parameter int CFG_W       = 16,
   parameter int DATA_W      = 14,
   parameter int CHAN_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int CONV_CYCLES = 64,
   localparam int CNT_W      = $clog2(CFG_W + DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   input  logic [DATA_W-1:0] result_in,
   output logic              sdo,
   output logic              sdo_oe,
   output logic [CHAN_W-1:0] conv_chan,
   output logic              late_err
);

   if (CHAN_W < 1 || CHAN_W > CFG_W) begin : g_bad_chan
      $error("adc_frame_if: CHAN_W must lie in 1..CFG_W");
   end
   if (DATA_W < 2 || CFG_W < 2) begin : g_bad_width
      $error("adc_frame_if: CFG_W and DATA_W must be at least 2");
   end

   logic [2:0]        pins_s;
   logic              cs_d, sclk_d;
   logic              cs_fall, cs_rise;
   frm_evt_t          evt;
   logic              busy;
   logic [DATA_W-1:0] result_q;
   logic [CHAN_W-1:0] cfg_chan, chan_q;
   logic              cfg_full;
   logic [CNT_W-1:0]  edge_cnt;

   adc_frame_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
      .clk(clk), .rst_n(rst_n), .din({cs_n, sclk, sdi}), .lvl(pins_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d   <= 1'b1;
         sclk_d <= 1'b1;
      end else begin
         cs_d   <= pins_s[PIN_CS];
         sclk_d <= pins_s[PIN_SCLK];
      end
   end

   assign cs_fall = cs_d & ~pins_s[PIN_CS];
   assign cs_rise = ~cs_d & pins_s[PIN_CS];
   assign evt = '{cs_fall:   cs_fall,
                  cs_rise:   cs_rise,
                  cs_act:    ~pins_s[PIN_CS],
                  sclk_fall: sclk_d & ~pins_s[PIN_SCLK],
                  sdi:       pins_s[PIN_SDI]};

   adc_frame_conv #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
      .clk(clk), .rst_n(rst_n), .start(cs_fall), .result_in(result_in),
      .busy(busy), .result_q(result_q)
   );

   adc_frame_serdes #(.CFG_W(CFG_W), .DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_serdes (
      .clk(clk), .rst_n(rst_n), .evt(evt), .busy(busy), .result_q(result_q),
      .sdo(sdo), .sdo_oe(sdo_oe), .late_err(late_err), .cfg_chan(cfg_chan),
      .cfg_full(cfg_full), .edge_cnt(edge_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_q    <= '0;
         conv_chan <= '0;
      end else begin
         if (cs_rise && cfg_full) chan_q <= cfg_chan;
         if (cs_fall) conv_chan <= chan_q;
      end
   end

endmodule

// File: rtl/adc_frame_if_chk.sv
module adc_frame_if_chk #(
   parameter int CFG_W  = 16,
   parameter int DATA_W = 14,
   parameter int CHAN_W = 3,
   localparam int CNT_W = $clog2(CFG_W + DATA_W + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_fall,
   input logic              cs_rise,
   input logic              sdo,
   input logic              sdo_oe,
   input logic              late_err,
   input logic              busy,
   input logic [DATA_W-1:0] result_q,
   input logic [CNT_W-1:0]  edge_cnt,
   input logic [CHAN_W-1:0] chan_q,
   input logic [CHAN_W-1:0] conv_chan
);

   AST_OE_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n) cs_fall |=> sdo_oe); // R1
   AST_HDR_LOW: assert property (@(posedge clk) disable iff (!rst_n) (sdo_oe && edge_cnt < CNT_W'(CFG_W)) |-> !sdo); // R1
   AST_OE_OFF_CLOSE: assert property (@(posedge clk) disable iff (!rst_n) cs_rise |=> !sdo_oe); // R2
   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !sdo_oe |-> !sdo); // R2
   AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (edge_cnt >= CNT_W'(CFG_W + DATA_W)) |-> !sdo); // R5
   AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cs_rise |=> $stable(chan_q)); // R6
   AST_CONV_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cs_fall |=> $stable(conv_chan)); // R6
   AST_LATE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) $rose(late_err) |-> $past(busy)); // R8
   AST_LATE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) cs_fall |=> !late_err); // R8
   AST_RESULT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(result_q) |-> $fell(busy)); // R9

endmodule

bind adc_frame_if adc_frame_if_chk #(.CFG_W(CFG_W), .DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise), .sdo(sdo),
   .sdo_oe(sdo_oe), .late_err(late_err), .busy(busy), .result_q(result_q),
   .edge_cnt(edge_cnt), .chan_q(chan_q), .conv_chan(conv_chan)
);

// File: tb/adc_frame_if_test.sv
`timescale 1ns/1ps
module adc_frame_if_test;

   localparam int SYNC = 2;
   localparam int CONV = 64;
   localparam int CW   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
   logic [13:0] result_in = '0;
   logic sdo, sdo_oe, late_err;
   logic [CW-1:0] conv_chan;

   int checks = 0, failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   adc_frame_if #(.CHAN_W(CW), .SYNC_STAGES(SYNC), .CONV_CYCLES(CONV)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .result_in(result_in), .sdo(sdo), .sdo_oe(sdo_oe),
      .conv_chan(conv_chan), .late_err(late_err)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit [2:0] hq[$];
   int  m_cnt, m_cfg, m_chan, m_cchan, m_el, m_res, m_snap;
   bit  m_oe, m_sdo, m_err, m_busy;

   always @(posedge clk) begin
      if (!rst_n) begin
         hq.delete();
         for (int i = 0; i < SYNC + 2; i++) hq.push_back(3'b110);
         m_cnt = 0; m_cfg = 0; m_chan = 0; m_cchan = 0; m_el = 0; m_res = 0; m_snap = 0;
         m_oe = 0; m_sdo = 0; m_err = 0; m_busy = 0;
      end else begin
         bit [2:0] cur, prv;
         bit cs_f, cs_r, sc_f, o_busy;
         int o_res, n;
         hq.push_front({cs_n, sclk, sdi});
         cur = hq[SYNC]; prv = hq[SYNC + 1];
         void'(hq.pop_back());
         cs_f = prv[2] && !cur[2];
         cs_r = !prv[2] && cur[2];
         sc_f = prv[1] && !cur[1];
         o_busy = m_busy; o_res = m_res;
         if (cs_f) begin
            m_busy = 1; m_el = 0;
         end else if (m_busy) begin
            if (m_el == CONV - 1) begin m_busy = 0; m_res = int'(result_in); end
            else m_el++;
         end
         if (cs_f) begin
            m_oe = 1; m_sdo = 0; m_cnt = 0; m_err = 0; m_cchan = m_chan;
         end else if (cs_r) begin
            m_oe = 0; m_sdo = 0;
            if (m_cnt >= 16) m_chan = m_cfg % (1 << CW);
         end else if (sc_f && !cur[2]) begin
            n = (m_cnt == 30) ? 30 : m_cnt + 1;
            if (n <= 16) m_cfg = ((m_cfg * 2) + int'(cur[0])) % 65536;
            if (n == 16) begin m_err = o_busy; m_snap = o_res; end
            if (n >= 16 && n < 30) m_sdo = m_snap[13 - (n - 16)];
            else if (n >= 30) m_sdo = 0;
            m_cnt = n;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R4", "model sdo", int'(sdo), int'(m_sdo));
         check("R2", "model sdo_oe", int'(sdo_oe), int'(m_oe));
         check("R8", "model late_err", int'(late_err), int'(m_err));
         check("R6", "model conv_chan", int'(conv_chan), m_cchan);
      end
   end

   // ---------------- stimulus ----------------
   task automatic frame(input bit [15:0] word, input int nedges, input int half,
                        input bit [13:0] ra, input bit [13:0] rb, input bit chk_data);
      bit pre[64];
      fork
         begin
            cs_n = 1'b0;
            repeat (half) @(negedge clk);
            for (int k = 1; k <= nedges; k++) begin
               sdi = (k <= 16) ? word[16 - k] : 1'b1;
               pre[k] = sdo;
               sclk = 1'b0;
               repeat (half) @(negedge clk);
               sclk = 1'b1;
               repeat (half) @(negedge clk);
            end
            pre[nedges + 1] = sdo;
            repeat (half) @(negedge clk);
            cs_n = 1'b1;
         end
         begin
            result_in = ra;
            repeat (10) @(negedge clk);
            result_in = rb;
            repeat (100) @(negedge clk);
            result_in = ~rb;
         end
      join
      repeat (8) @(negedge clk);
      check("R2", "oe after close", int'(sdo_oe), 0);
      if (chk_data) begin
         bit [13:0] got = '0;
         for (int k = 2; k <= 16 && k <= nedges + 1; k++)
            check("R1", $sformatf("sdo before fall %0d", k), int'(pre[k]), 0);
         if (nedges >= 30) begin
            for (int k = 17; k <= 30; k++) got[30 - k] = pre[k];
            check("R4", "result word read by host", int'(got), int'(rb));
            check("R9", "captured at conversion end", int'(got), int'(rb));
         end
         for (int k = 31; k <= nedges + 1; k++)
            check("R5", $sformatf("tail before fall %0d", k), int'(pre[k]), 0);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check("R11", "reset sdo", int'(sdo), 0);
      check("R11", "reset sdo_oe", int'(sdo_oe), 0);
      check("R11", "reset late_err", int'(late_err), 0);
      check("R11", "reset conv_chan", int'(conv_chan), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      frame(16'hA5C5, 30, 5, 14'h1111, 14'h2D3B, 1'b1);
      check("R8", "no late flag on slow frame", int'(late_err), 0);
      check("R6", "first frame converts reset channel", int'(conv_chan), 0);

      frame(16'h3C03, 34, 5, 14'h0F0F, 14'h3ACE, 1'b1);
      check("R6", "channel from previous word", int'(conv_chan), 5);

      frame(16'hFFF6, 10, 5, 14'h0001, 14'h0002, 1'b1);
      check("R3", "trailing sdi ignored", int'(conv_chan), 3);

      frame(16'h0001, 20, 5, 14'h1234, 14'h0555, 1'b1);
      check("R7", "short frame discarded", int'(conv_chan), 3);

      // serial clock activity while the frame is closed
      for (int i = 0; i < 12; i++) begin
         sdi = i[0];
         sclk = ~sclk;
         repeat (3) @(negedge clk);
         check("R10", "oe stays low while deselected", int'(sdo_oe), 0);
      end
      sclk = 1'b1;
      repeat (4) @(negedge clk);

      frame(16'h8002, 20, 1, 14'h0AAA, 14'h1555, 1'b0);
      check("R8", "late flag on fast frame", int'(late_err), 1);
      check("R10", "idle edges left channel", int'(conv_chan), 1);

      frame(16'h4444, 32, 5, 14'h3FFF, 14'h2001, 1'b1);
      check("R8", "late flag cleared by new frame", int'(late_err), 0);
      check("R6", "channel after fast frame", int'(conv_chan), 2);

      repeat (10) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog R1 actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule